// File: doc/BRIEF.md
# Prioritised Interrupt Dispatcher

This block decides which pending interrupt a processor core takes next. Pre-decoded program-check and supervisor-call requests come first. After them, three asynchronous classes are considered in a fixed order: machine check, external and I/O. A class is considered only when its enable bit in the current status word is set. External interrupts arrive through a small last-in-first-out queue, and two timer sources (clock comparator and CPU timer) sit beside that queue. The I/O class has eight subclasses, each with its own queue, and a subclass mask selects which of them may deliver.

A selected interrupt is offered on a save stream. The stream carries the vector, the interruption code and parameter, and the instruction length. It also carries the old status word with the live condition code merged in and the old address. The handshake completes on a cycle where `save_valid` and `save_ready` are both high. On that same clock edge the dispatcher pops the source, clears the matching pending flag, and loads the new status word that the environment presents on `vec_mask`/`vec_addr` for the offered vector. While `save_ready` is low, the offer stays stable and nothing is consumed. The queue push ports are valid/ready: a push is accepted only while its queue is not full. A push offered to a full queue is dropped and reported on `ovf_o`.

Top module: `intr_dispatch`

## Requirements
- R1: Vectors are program check (0), supervisor call (1), machine check (2), external (3) and I/O (4). A program request beats a supervisor request, and both beat all asynchronous classes. Then the order is machine check, external, I/O. Each asynchronous class is gated by its status-word enable: bit 50 for machine check, bit 56 for external and bit 57 for I/O.
- R2: Within the external class, the most recently queued entry wins and is delivered with its own code and parameter. Next is a clock-comparator event with code 0x1004, then a CPU-timer event with code 0x1005. A timer flag is cleared when it is taken, unless a new event arrives in the same cycle.
- R3: A pending machine check, with its enable bit set, is delivered only while `mck_gate` is high. Otherwise it stays pending, `save_valid` is low, and no lower class is offered.
- R4: I/O subclasses are scanned from 0 upward. The first non-empty subclass whose bit in `io_sub_mask` is set is offered, with its subclass number as the code. Entries in masked subclasses stay queued. If no subclass qualifies, nothing is offered.
- R5: Every queue holds 8 entries in last-in-first-out order. The ready outputs are high exactly when the addressed queue is not full. A push offered to a full queue is dropped, and so is a machine-check event when 8 are already pending; either case raises `ovf_o` for one cycle on the following cycle.
- R6: `save_old_mask` equals the current status word with bits 45:44 replaced by `cc_in`. On the handshake, the status word and address load from `vec_mask`/`vec_addr`, and `cc_o` shows bits 45:44 of the loaded word. A handshake load takes precedence over `sw_wr`.
- R7: A handshake that loads a word with the wait bit (49) set and bits 57, 56 and 50 all clear pulses `halt_o` for one cycle.
- R8: `save_ilen` carries the request length for program (2, 4 or 6) and supervisor requests, and is 0 otherwise. The old address is advanced by that length for a supervisor call, and for a program check that has `pgm_defer` set.
- R9: `irq_o` is high exactly while any queue entry, timer flag or machine check is pending.
- R10: While `save_valid` is high and `save_ready` is low, the offer is held and the status word is unchanged (absent `sw_wr`).
- R11: After reset, all queues are empty, all flags are clear and the status word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Load status word directly |
| sw_wr_mask | input | 64 | Status word for direct load |
| sw_wr_addr | input | AW | Address for direct load |
| cc_in | input | 2 | Live condition code |
| pgm_req | input | 1 | Program-check request (held until taken) |
| pgm_code | input | 16 | Program interruption code |
| pgm_ilen | input | 3 | Program instruction length |
| pgm_defer | input | 1 | Advance saved address by length |
| svc_req | input | 1 | Supervisor-call request |
| svc_code | input | 16 | Supervisor-call code |
| svc_ilen | input | 3 | Supervisor-call instruction length |
| mck_evt | input | 1 | Machine-check event strobe |
| mck_gate | input | 1 | Machine-check delivery enable (control register) |
| tod_evt | input | 1 | Clock-comparator event strobe |
| cpt_evt | input | 1 | CPU-timer event strobe |
| ext_push_valid | input | 1 | External queue push valid |
| ext_push_ready | output | 1 | External queue not full |
| ext_push_code | input | 16 | External interruption code |
| ext_push_parm | input | 32 | External parameter |
| io_push_valid | input | 1 | I/O queue push valid |
| io_push_ready | output | 1 | Addressed I/O queue not full |
| io_push_sub | input | SUBW | I/O subclass of push |
| io_push_parm | input | 32 | I/O parameter |
| io_sub_mask | input | NSUB | Subclass delivery enables (control register) |
| save_valid | output | 1 | Interrupt offered |
| save_ready | input | 1 | Accept strobe |
| save_vec | output | 3 | Vector of offered interrupt |
| save_code | output | 16 | Interruption code |
| save_parm | output | 32 | Interruption parameter |
| save_ilen | output | 3 | Instruction length |
| save_old_mask | output | 64 | Old status word with condition code |
| save_old_addr | output | AW | Old address |
| vec_mask | input | 64 | New status word for offered vector |
| vec_addr | input | AW | New address for offered vector |
| sw_mask_o | output | 64 | Current status word |
| sw_addr_o | output | AW | Current address |
| cc_o | output | 2 | Condition code of current word |
| halt_o | output | 1 | Halt pulse after a wait-state load |
| irq_o | output | 1 | Anything pending |
| ovf_o | output | 1 | Dropped push or event |

## Verification
The bench pushes two external entries and expects them back newest-first. A queue wired first-in-first-out would return the older entry first. A pending machine check with its delivery gate low must block a ready external entry; a dispatcher that fell through to the next class would offer the external entry instead. Subclass 5 is queued beside a masked subclass 2 and must win. After the mask opens, subclass 2 must follow, which catches a scan in the wrong direction or one that ignores the mask. Further cases cover simultaneous timer events (0x1004 before 0x1005), a ninth push into a full queue, a wait-state load with every enable clear, and a held offer under back-pressure that must not pop or reload.

// File: rtl/intd_pkg.sv
package intd_pkg;
  typedef enum logic [2:0] {
    VEC_PGM  = 3'd0,
    VEC_SVC  = 3'd1,
    VEC_MCK  = 3'd2,
    VEC_EXT  = 3'd3,
    VEC_IO   = 3'd4,
    VEC_NONE = 3'd7
  } vec_e;

  typedef enum logic [1:0] {
    SRC_QUEUE  = 2'd0,
    SRC_CLKCMP = 2'd1,
    SRC_CPUTMR = 2'd2
  } xsrc_e;

  localparam int SW_IO_EN  = 57;
  localparam int SW_EXT_EN = 56;
  localparam int SW_MCK_EN = 50;
  localparam int SW_WAIT   = 49;
  localparam int SW_CC_LO  = 44;

  localparam logic [15:0] CODE_CLKCMP = 16'h1004;
  localparam logic [15:0] CODE_CPUTMR = 16'h1005;
endpackage

// File: rtl/intd_lifo.sv
module intd_lifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_m1;
  logic [CW-1:0] wr_pos;

  always_comb begin
    cnt_m1 = cnt - CW'(1);
    wr_pos = pop ? cnt_m1 : cnt;
    empty  = (cnt == '0);
    full   = (cnt == CW'(DEPTH));
    dout   = empty ? '0 : mem[cnt_m1[IW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_pos[IW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt_m1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/intd_iobank.sv
module intd_iobank #(
  parameter int NSUB  = 8,
  parameter int DEPTH = 8,
  parameter int W     = 32,
  parameter int SUBW  = $clog2(NSUB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [SUBW-1:0] push_sub,
  input  logic [W-1:0]    push_din,
  output logic            push_ready,
  input  logic            pop,
  input  logic [NSUB-1:0] sub_mask,
  output logic            any_pend,
  output logic            hit,
  output logic [SUBW-1:0] hit_sub,
  output logic [W-1:0]    hit_data
);
  logic [NSUB-1:0] empty_v, full_v;
  logic [W-1:0]    top_v [NSUB];

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    intd_lifo #(.W(W), .DEPTH(DEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push && (push_sub == SUBW'(g)) && !full_v[g]),
      .pop   (pop && (hit_sub == SUBW'(g))),
      .din   (push_din),
      .dout  (top_v[g]),
      .empty (empty_v[g]),
      .full  (full_v[g])
    );
  end

  always_comb begin
    push_ready = !full_v[push_sub];
    any_pend   = !(&empty_v);
    hit        = 1'b0;
    hit_sub    = '0;
    hit_data   = '0;
    for (int i = 0; i < NSUB; i++) begin
      if (!hit && !empty_v[i] && sub_mask[i]) begin
        hit      = 1'b1;
        hit_sub  = SUBW'(i);
        hit_data = top_v[i];
      end
    end
  end
endmodule

// File: rtl/intd_prio.sv
module intd_prio import intd_pkg::*; (
  input  logic  pgm_req,
  input  logic  svc_req,
  input  logic  en_mck,
  input  logic  en_ext,
  input  logic  en_io,
  input  logic  mck_pend,
  input  logic  mck_gate,
  input  logic  ext_q_pend,
  input  logic  tod_pend,
  input  logic  cpt_pend,
  input  logic  io_any,
  input  logic  io_hit,
  output vec_e  vec,
  output logic  valid,
  output xsrc_e ext_src
);
  always_comb begin
    vec     = VEC_NONE;
    valid   = 1'b0;
    ext_src = SRC_QUEUE;
    if (pgm_req) begin
      vec   = VEC_PGM;
      valid = 1'b1;
    end else if (svc_req) begin
      vec   = VEC_SVC;
      valid = 1'b1;
    end else if (en_mck && mck_pend) begin
      vec   = VEC_MCK;
      valid = mck_gate;
    end else if (en_ext && (ext_q_pend || tod_pend || cpt_pend)) begin
      vec   = VEC_EXT;
      valid = 1'b1;
      if (ext_q_pend)    ext_src = SRC_QUEUE;
      else if (tod_pend) ext_src = SRC_CLKCMP;
      else               ext_src = SRC_CPUTMR;
    end else if (en_io && io_any) begin
      vec   = VEC_IO;
      valid = io_hit;
    end
  end
endmodule

// File: rtl/intr_dispatch.sv
module intr_dispatch import intd_pkg::*; #(
  parameter int AW     = 32,
  parameter int QDEPTH = 8,
  parameter int NSUB   = 8,
  parameter int CODE_W = 16,
  parameter int PARM_W = 32,
  parameter int SUBW   = $clog2(NSUB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [63:0]       sw_wr_mask,
  input  logic [AW-1:0]     sw_wr_addr,
  input  logic [1:0]        cc_in,
  input  logic              pgm_req,
  input  logic [CODE_W-1:0] pgm_code,
  input  logic [2:0]        pgm_ilen,
  input  logic              pgm_defer,
  input  logic              svc_req,
  input  logic [CODE_W-1:0] svc_code,
  input  logic [2:0]        svc_ilen,
  input  logic              mck_evt,
  input  logic              mck_gate,
  input  logic              tod_evt,
  input  logic              cpt_evt,
  input  logic              ext_push_valid,
  output logic              ext_push_ready,
  input  logic [CODE_W-1:0] ext_push_code,
  input  logic [PARM_W-1:0] ext_push_parm,
  input  logic              io_push_valid,
  output logic              io_push_ready,
  input  logic [SUBW-1:0]   io_push_sub,
  input  logic [PARM_W-1:0] io_push_parm,
  input  logic [NSUB-1:0]   io_sub_mask,
  output logic              save_valid,
  input  logic              save_ready,
  output logic [2:0]        save_vec,
  output logic [CODE_W-1:0] save_code,
  output logic [PARM_W-1:0] save_parm,
  output logic [2:0]        save_ilen,
  output logic [63:0]       save_old_mask,
  output logic [AW-1:0]     save_old_addr,
  input  logic [63:0]       vec_mask,
  input  logic [AW-1:0]     vec_addr,
  output logic [63:0]       sw_mask_o,
  output logic [AW-1:0]     sw_addr_o,
  output logic [1:0]        cc_o,
  output logic              halt_o,
  output logic              irq_o,
  output logic              ovf_o
);
  localparam int CW = $clog2(QDEPTH + 1);
  localparam int EW = CODE_W + PARM_W;

  logic [63:0]       sw_mask_q;
  logic [AW-1:0]     sw_addr_q;
  logic              tod_q, cpt_q, halt_q, ovf_q;
  logic [CW-1:0]     mck_cnt;
  logic              mck_pend, mck_full, mck_ok, mck_take;
  logic [EW-1:0]     ext_top;
  logic              ext_empty, ext_full, ext_pop, ext_push;
  logic              io_any, io_hit, io_pop;
  logic [SUBW-1:0]   io_hit_sub;
  logic [PARM_W-1:0] io_hit_data;
  vec_e              vec;
  xsrc_e             ext_src;
  logic              sel_valid, fire, adv, ext_timer_take;

  intd_prio u_prio (
    .pgm_req    (pgm_req),
    .svc_req    (svc_req),
    .en_mck     (sw_mask_q[SW_MCK_EN]),
    .en_ext     (sw_mask_q[SW_EXT_EN]),
    .en_io      (sw_mask_q[SW_IO_EN]),
    .mck_pend   (mck_pend),
    .mck_gate   (mck_gate),
    .ext_q_pend (!ext_empty),
    .tod_pend   (tod_q),
    .cpt_pend   (cpt_q),
    .io_any     (io_any),
    .io_hit     (io_hit),
    .vec        (vec),
    .valid      (sel_valid),
    .ext_src    (ext_src)
  );

  intd_lifo #(.W(EW), .DEPTH(QDEPTH)) u_extq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ext_push),
    .pop   (ext_pop),
    .din   ({ext_push_code, ext_push_parm}),
    .dout  (ext_top),
    .empty (ext_empty),
    .full  (ext_full)
  );

  intd_iobank #(.NSUB(NSUB), .DEPTH(QDEPTH), .W(PARM_W), .SUBW(SUBW)) u_io (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (io_push_valid),
    .push_sub   (io_push_sub),
    .push_din   (io_push_parm),
    .push_ready (io_push_ready),
    .pop        (io_pop),
    .sub_mask   (io_sub_mask),
    .any_pend   (io_any),
    .hit        (io_hit),
    .hit_sub    (io_hit_sub),
    .hit_data   (io_hit_data)
  );

  always_comb begin
    fire           = sel_valid && save_ready;
    ext_push_ready = !ext_full;
    ext_push       = ext_push_valid && !ext_full;
    ext_pop        = fire && (vec == VEC_EXT) && (ext_src == SRC_QUEUE);
    ext_timer_take = fire && (vec == VEC_EXT);
    io_pop         = fire && (vec == VEC_IO);
    mck_pend       = (mck_cnt != '0);
    mck_full       = (mck_cnt == CW'(QDEPTH));
    mck_ok         = mck_evt && !mck_full;
    mck_take       = fire && (vec == VEC_MCK);

    save_valid = sel_valid;
    save_vec   = vec;
    save_code  = '0;
    save_parm  = '0;
    save_ilen  = 3'd0;
    case (vec)
      VEC_PGM: begin save_code = pgm_code; save_ilen = pgm_ilen; end
      VEC_SVC: begin save_code = svc_code; save_ilen = svc_ilen; end
      VEC_EXT: begin
        case (ext_src)
          SRC_QUEUE:  {save_code, save_parm} = ext_top;
          SRC_CLKCMP: save_code = CODE_CLKCMP;
          default:    save_code = CODE_CPUTMR;
        endcase
      end
      VEC_IO: begin
        save_code = CODE_W'(io_hit_sub);
        save_parm = io_hit_data;
      end
      default: ;
    endcase
    adv           = ((vec == VEC_PGM) && pgm_defer) || (vec == VEC_SVC);
    save_old_addr = sw_addr_q + (adv ? AW'(save_ilen) : '0);
    save_old_mask = sw_mask_q;
    save_old_mask[SW_CC_LO +: 2] = cc_in;

    sw_mask_o = sw_mask_q;
    sw_addr_o = sw_addr_q;
    cc_o      = sw_mask_q[SW_CC_LO +: 2];
    halt_o    = halt_q;
    ovf_o     = ovf_q;
    irq_o     = !ext_empty || tod_q || cpt_q || mck_pend || io_any;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_mask_q <= '0;
      sw_addr_q <= '0;
      tod_q     <= 1'b0;
      cpt_q     <= 1'b0;
      halt_q    <= 1'b0;
      ovf_q     <= 1'b0;
      mck_cnt   <= '0;
    end else begin
      tod_q  <= tod_evt || (tod_q && !(ext_timer_take && ext_src == SRC_CLKCMP));
      cpt_q  <= cpt_evt || (cpt_q && !(ext_timer_take && ext_src == SRC_CPUTMR));
      ovf_q  <= (ext_push_valid && ext_full) || (io_push_valid && !io_push_ready)
                || (mck_evt && mck_full);
      halt_q <= fire && vec_mask[SW_WAIT] && !vec_mask[SW_IO_EN]
                && !vec_mask[SW_EXT_EN] && !vec_mask[SW_MCK_EN];
      case ({mck_ok, mck_take})
        2'b10:   mck_cnt <= mck_cnt + CW'(1);
        2'b01:   mck_cnt <= mck_cnt - CW'(1);
        default: mck_cnt <= mck_cnt;
      endcase
      if (fire) begin
        sw_mask_q <= vec_mask;
        sw_addr_q <= vec_addr;
      end else if (sw_wr) begin
        sw_mask_q <= sw_wr_mask;
        sw_addr_q <= sw_wr_addr;
      end
    end
  end
endmodule

// File: rtl/intr_dispatch_chk.sv
module intr_dispatch_chk #(
  parameter int NSUB = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pgm_req,
  input logic [2:0]      pgm_ilen,
  input logic            svc_req,
  input logic            sw_wr,
  input logic            save_valid,
  input logic            save_ready,
  input logic [2:0]      save_vec,
  input logic [15:0]     save_code,
  input logic [63:0]     sw_mask_o,
  input logic            halt_o,
  input logic            ovf_o,
  input logic            ext_push_valid,
  input logic            ext_push_ready,
  input logic [NSUB-1:0] io_sub_mask,
  input logic            mck_pend,
  input logic            mck_gate
);
  assert_legal_ilen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |-> (pgm_ilen == 3'd2 || pgm_ilen == 3'd4 || pgm_ilen == 3'd6));

  assert_hold_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (save_valid && !save_ready && !sw_wr) |=> $stable(sw_mask_o));

  assert_halt_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> (sw_mask_o[49] && !sw_mask_o[57] && !sw_mask_o[56] && !sw_mask_o[50]));

  assert_mck_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pgm_req && !svc_req && sw_mask_o[50] && mck_pend && !mck_gate) |-> !save_valid);

  assert_drop_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_push_valid && !ext_push_ready) |=> ovf_o);

  assert_ext_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (save_valid && save_vec == 3'd3) |-> sw_mask_o[56]);

  assert_io_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (save_valid && save_vec == 3'd4) |-> io_sub_mask[save_code[$clog2(NSUB)-1:0]]);
endmodule

bind intr_dispatch intr_dispatch_chk #(.NSUB(NSUB)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pgm_req        (pgm_req),
  .pgm_ilen       (pgm_ilen),
  .svc_req        (svc_req),
  .sw_wr          (sw_wr),
  .save_valid     (save_valid),
  .save_ready     (save_ready),
  .save_vec       (save_vec),
  .save_code      (save_code),
  .sw_mask_o      (sw_mask_o),
  .halt_o         (halt_o),
  .ovf_o          (ovf_o),
  .ext_push_valid (ext_push_valid),
  .ext_push_ready (ext_push_ready),
  .io_sub_mask    (io_sub_mask),
  .mck_pend       (mck_pend),
  .mck_gate       (mck_gate)
);

// File: tb/intr_dispatch_bench.sv
`timescale 1ns/1ps
module intr_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_wr;
  logic [63:0] sw_wr_mask;
  logic [31:0] sw_wr_addr;
  logic [1:0]  cc_in;
  logic        pgm_req, pgm_defer, svc_req;
  logic [15:0] pgm_code, svc_code;
  logic [2:0]  pgm_ilen, svc_ilen;
  logic        mck_evt, mck_gate, tod_evt, cpt_evt;
  logic        ext_push_valid, ext_push_ready;
  logic [15:0] ext_push_code;
  logic [31:0] ext_push_parm;
  logic        io_push_valid, io_push_ready;
  logic [2:0]  io_push_sub;
  logic [31:0] io_push_parm;
  logic [7:0]  io_sub_mask;
  logic        save_valid, save_ready;
  logic [2:0]  save_vec, save_ilen;
  logic [15:0] save_code;
  logic [31:0] save_parm, save_old_addr, vec_addr, sw_addr_o;
  logic [63:0] save_old_mask, vec_mask, sw_mask_o;
  logic [1:0]  cc_o;
  logic        halt_o, irq_o, ovf_o;

  int vectors = 0;
  int fails   = 0;

  logic [47:0] m_ext [8];
  int          m_ecnt;
  logic [31:0] m_io [8][8];
  int          m_iocnt [8];
  int          m_mck;
  bit          m_tod, m_cpt, m_halt, m_ovf;
  logic [63:0] m_mask;
  logic [31:0] m_addr;

  localparam logic [63:0] ALL_EN = 64'h0304_2000_0000_0000;

  always #10 clk = ~clk;

  intr_dispatch u_intr_dispatch (.*);

  task automatic chk(string rq, string nm, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", rq, nm, act, exp, $time);
    end
  endtask

  task automatic clear_inputs();
    sw_wr = 0; sw_wr_mask = '0; sw_wr_addr = '0; cc_in = 0;
    pgm_req = 0; pgm_code = 0; pgm_ilen = 3'd2; pgm_defer = 0;
    svc_req = 0; svc_code = 0; svc_ilen = 3'd2;
    mck_evt = 0; mck_gate = 0; tod_evt = 0; cpt_evt = 0;
    ext_push_valid = 0; ext_push_code = 0; ext_push_parm = 0;
    io_push_valid = 0; io_push_sub = 0; io_push_parm = 0; io_sub_mask = 0;
    save_ready = 0; vec_mask = ALL_EN; vec_addr = 32'h1000;
  endtask

  task automatic step();
    logic        ev;
    logic [2:0]  vv, el;
    logic [15:0] ec;
    logic [31:0] ep, oa;
    logic [63:0] om;
    int          isc, src, eb, ib, mb, pi;
    bit          anyio, fire;
    string       tv;
    #1;
    anyio = 0;
    for (int i = 0; i < 8; i++) if (m_iocnt[i] > 0) anyio = 1;
    ev = 0; vv = 3'd7; ec = 0; ep = 0; el = 0; isc = -1; src = 0; tv = "R1";
    if (pgm_req) begin
      ev = 1; vv = 3'd0; ec = pgm_code; el = pgm_ilen;
    end else if (svc_req) begin
      ev = 1; vv = 3'd1; ec = svc_code; el = svc_ilen;
    end else if (m_mask[50] && m_mck > 0) begin
      tv = "R3";
      if (mck_gate) begin ev = 1; vv = 3'd2; end
    end else if (m_mask[56] && (m_ecnt > 0 || m_tod || m_cpt)) begin
      ev = 1; vv = 3'd3; tv = "R2";
      if (m_ecnt > 0) begin
        ec = m_ext[m_ecnt-1][47:32]; ep = m_ext[m_ecnt-1][31:0]; src = 0;
      end else if (m_tod) begin
        ec = 16'h1004; src = 1;
      end else begin
        ec = 16'h1005; src = 2;
      end
    end else if (m_mask[57] && anyio) begin
      tv = "R4";
      for (int i = 0; i < 8; i++)
        if (isc < 0 && m_iocnt[i] > 0 && io_sub_mask[i]) isc = i;
      if (isc >= 0) begin
        ev = 1; vv = 3'd4; ec = 16'(isc); ep = m_io[isc][m_iocnt[isc]-1];
      end
    end
    om = m_mask; om[45:44] = cc_in;
    oa = m_addr + ((((vv == 3'd0) && pgm_defer) || (vv == 3'd1)) ? 32'(el) : 32'd0);

    chk(tv, "save_valid", 64'(save_valid), 64'(ev));
    if (ev) begin
      chk(tv, "save_vec", 64'(save_vec), 64'(vv));
      chk(tv, "save_code", 64'(save_code), 64'(ec));
      chk(tv, "save_parm", 64'(save_parm), 64'(ep));
      chk("R8", "save_ilen", 64'(save_ilen), 64'(el));
      chk("R6", "save_old_mask", save_old_mask, om);
      chk("R8", "save_old_addr", 64'(save_old_addr), 64'(oa));
    end
    chk("R9", "irq_o", 64'(irq_o), 64'(anyio || m_ecnt > 0 || m_tod || m_cpt || m_mck > 0));
    chk("R7", "halt_o", 64'(halt_o), 64'(m_halt));
    chk("R5", "ovf_o", 64'(ovf_o), 64'(m_ovf));
    chk("R6", "sw_mask_o", sw_mask_o, m_mask);
    chk("R6", "sw_addr_o", 64'(sw_addr_o), 64'(m_addr));
    chk("R6", "cc_o", 64'(cc_o), 64'(m_mask[45:44]));
    chk("R5", "ext_push_ready", 64'(ext_push_ready), 64'(m_ecnt < 8));
    chk("R5", "io_push_ready", 64'(io_push_ready), 64'(m_iocnt[io_push_sub] < 8));

    fire = ev && save_ready;
    eb = m_ecnt; pi = int'(io_push_sub); ib = m_iocnt[pi]; mb = m_mck;
    m_ovf = (ext_push_valid && eb >= 8) || (io_push_valid && ib >= 8) || (mck_evt && mb >= 8);
    if (fire && vv == 3'd3 && src == 0) m_ecnt--;
    if (ext_push_valid && eb < 8) begin
      m_ext[m_ecnt] = {ext_push_code, ext_push_parm}; m_ecnt++;
    end
    if (fire && vv == 3'd4) m_iocnt[isc]--;
    if (io_push_valid && ib < 8) begin
      m_io[pi][m_iocnt[pi]] = io_push_parm; m_iocnt[pi]++;
    end
    m_tod = tod_evt || (m_tod && !(fire && vv == 3'd3 && src == 1));
    m_cpt = cpt_evt || (m_cpt && !(fire && vv == 3'd3 && src == 2));
    if (fire && vv == 3'd2) m_mck--;
    if (mck_evt && mb < 8) m_mck++;
    m_halt = fire && vec_mask[49] && !vec_mask[57] && !vec_mask[56] && !vec_mask[50];
    if (fire) begin
      m_mask = vec_mask; m_addr = vec_addr;
    end else if (sw_wr) begin
      m_mask = sw_wr_mask; m_addr = sw_wr_addr;
    end
    @(negedge clk);
  endtask

  task automatic rnd_inputs();
    logic [63:0] vm;
    clear_inputs();
    pgm_req   = ($urandom % 16) == 0;
    pgm_code  = 16'($urandom);
    pgm_ilen  = 3'(2 * (1 + $urandom % 3));
    pgm_defer = 1'($urandom);
    svc_req   = ($urandom % 16) == 0;
    svc_code  = 16'($urandom);
    svc_ilen  = 3'(2 * (1 + $urandom % 3));
    cc_in     = 2'($urandom);
    save_ready = ($urandom % 4) != 0;
    ext_push_valid = ($urandom % 3) == 0;
    ext_push_code  = 16'($urandom);
    ext_push_parm  = $urandom;
    io_push_valid  = ($urandom % 2) == 0;
    io_push_sub    = 3'($urandom);
    io_push_parm   = $urandom;
    io_sub_mask    = 8'($urandom);
    mck_evt  = ($urandom % 10) == 0;
    mck_gate = 1'($urandom);
    tod_evt  = ($urandom % 20) == 0;
    cpt_evt  = ($urandom % 20) == 0;
    vm = {$urandom, $urandom};
    vm[57] = ($urandom % 4) != 0;
    vm[56] = ($urandom % 4) != 0;
    vm[50] = ($urandom % 4) != 0;
    vec_mask = vm;
    vec_addr = $urandom;
    sw_wr = ($urandom % 50) == 0;
    sw_wr_mask = {$urandom, $urandom} | ALL_EN;
    sw_wr_addr = $urandom;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog act=timeout exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd7001));
    clear_inputs();
    rst_n = 0;
    m_ecnt = 0; m_mck = 0; m_tod = 0; m_cpt = 0; m_halt = 0; m_ovf = 0;
    m_mask = '0; m_addr = '0;
    for (int i = 0; i < 8; i++) m_iocnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "save_valid", 64'(save_valid), 64'd0);
    chk("R11", "irq_o", 64'(irq_o), 64'd0);
    chk("R11", "sw_mask_o", sw_mask_o, 64'd0);
    chk("R11", "halt_o", 64'(halt_o), 64'd0);
    chk("R11", "ovf_o", 64'(ovf_o), 64'd0);
    rst_n = 1;

    sw_wr = 1; sw_wr_mask = ALL_EN; sw_wr_addr = 32'h200; step();
    clear_inputs();
    // R2 / R5: LIFO order in the external queue
    ext_push_valid = 1; ext_push_code = 16'hA001; ext_push_parm = 32'h11; step();
    ext_push_code = 16'hB002; ext_push_parm = 32'h22; step();
    clear_inputs();
    // R10: held offer under back-pressure
    step();
    held = save_code;
    step();
    chk("R10", "held code", 64'(save_code), 64'(held));
    chk("R10", "held code newest", 64'(held), 64'hB002);
    save_ready = 1; step(); step(); step();
    // R2: timer sources, clock comparator first
    clear_inputs(); tod_evt = 1; cpt_evt = 1; step();
    clear_inputs(); save_ready = 1; step(); step(); step();
    // R3: gated machine check blocks the external class
    clear_inputs(); mck_evt = 1; ext_push_valid = 1; ext_push_code = 16'hC003; step();
    clear_inputs(); save_ready = 1; mck_gate = 0; step();
    chk("R3", "blocked valid", 64'(save_valid), 64'd0);
    mck_gate = 1; step(); step(); step();
    // R4: ascending scan with subclass mask
    clear_inputs(); io_push_valid = 1; io_push_sub = 3'd5; io_push_parm = 32'h55; step();
    io_push_sub = 3'd2; io_push_parm = 32'h22; step();
    clear_inputs(); save_ready = 1; io_sub_mask = 8'h20; step();
    chk("R4", "masked sub stays", 64'(irq_o), 64'd1);
    io_sub_mask = 8'h00; step();
    io_sub_mask = 8'hFF; step(); step();
    // R5: ninth push into a full queue
    clear_inputs(); ext_push_valid = 1;
    for (int k = 0; k < 9; k++) begin ext_push_code = 16'(k); step(); end
    clear_inputs(); step();
    save_ready = 1; for (int k = 0; k < 9; k++) step();
    // R7: wait-state load with every enable clear
    clear_inputs(); pgm_req = 1; pgm_ilen = 3'd4; pgm_defer = 1;
    save_ready = 1; vec_mask = 64'h0002_0000_0000_0000; step();
    clear_inputs(); step();
    sw_wr = 1; sw_wr_mask = ALL_EN; step();
    // random mix
    for (int n = 0; n < 3000; n++) begin
      rnd_inputs();
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule